// File: doc/BRIEF.md
# Dual-Mode Width-Configurable Register File

This block keeps the programmer-visible working registers of an 8/16-bit processor core: an accumulator whose upper byte can be hidden, two index registers, a stack pointer, a direct-page base and an 8-bit status byte. It also keeps a mode bit that does not appear in the status byte. In the compatibility (emulation) mode the accumulator and index registers act as 8-bit registers and the stack is confined to one page. In the extended (native) mode two status bits pick the accumulator width and the index width on their own.

The decode stage sends the block one micro-operation per cycle. The operation can load an immediate, copy one register to another, set or clear status bits under a mask, exchange carry with the mode bit, or swap the two accumulator bytes. The block tells the datapath the current operand widths. It also applies the width rules to register contents: it clears index upper bytes, forces the stack page and keeps the hidden accumulator byte. A combinational read port returns any register, zero-extended when that register is 8 bits wide.

Top module: `modal_regfile`

## Requirements
- R1: After reset, e_flag is 1, status is 0x34, m_eff and x_eff are 1, the stack pointer reads 0x01FF, and the accumulator, both index registers and direct page read 0.
- R2: The exchange operation (op_code 5) swaps the mode bit with status bit 0 (carry). The mode bit is visible only on e_flag.
- R3: Status bit 5 is the accumulator width flag (m_eff) and bit 4 is the index width flag (x_eff); 1 means 8 bits and 0 means 16 bits. Op 3 ORs op_mask into status and op 4 clears the status bits set in op_mask.
- R4: While e_flag is 1, status bits 5 and 4 stay 1 whatever mask op 4 applies.
- R5: On a switch from emulation to native mode, the index registers have zero upper bytes, m_eff and x_eff stay 1, and the hidden upper accumulator byte keeps its value.
- R6: When x_eff goes from 0 to 1, the upper bytes of both index registers become 0 and stay 0 after a later return to 16 bits.
- R7: When m_eff goes to 1, the hidden upper accumulator byte keeps its value, and it shows again after a return to 16 bits.
- R8: The swap operation (op_code 6) exchanges the accumulator's low and high bytes. N (status bit 7) and Z (status bit 1) then follow the new low byte.
- R9: A copy (op_code 2) between the accumulator (select 0) and the stack pointer (3) or direct page (4), in either direction, moves all 16 bits whatever m_eff is.
- R10: A load (op_code 1) or copy into the accumulator with m_eff=1 writes only the low byte. Into an index register (1, 2) with x_eff=1 it writes the low byte and clears the upper byte. N and Z follow the written value at the destination width, and the direct page is always 16 bits wide. A write into the stack pointer leaves N and Z unchanged.
- R11: While e_flag is 1, the stack pointer upper byte is 0x01. Entering emulation mode forces m_eff and x_eff to 1, clears the index upper bytes and sets the stack page to 0x01.
- R12: The read port returns the accumulator or an index register zero-extended to 16 bits when that register is 8 bits wide. Select codes 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Micro-operation present this cycle |
| op_code | input | 3 | 0 none, 1 load, 2 copy, 3 set bits, 4 clear bits, 5 exchange carry/mode, 6 byte swap |
| op_dst | input | 3 | Destination select: 0 acc, 1 index0, 2 index1, 3 stack, 4 direct page |
| op_src | input | 3 | Copy source select, same coding |
| op_data | input | 16 | Load immediate |
| op_mask | input | 8 | Status mask for set/clear |
| rd_sel | input | 3 | Read port select, same coding |
| rd_data | output | 16 | Read port value, zero-extended at 8-bit width |
| m_eff | output | 1 | Accumulator is 8 bits wide |
| x_eff | output | 1 | Index registers are 8 bits wide |
| e_flag | output | 1 | Emulation mode active |
| status | output | 8 | Status byte |

## Verification
The assertions check on every cycle that emulation mode forces both width flags, that the index upper bytes are zero while x_eff is 1, and that the stack page is fixed while e_flag is 1. They also check the exchange of carry and mode bit, the byte swap, and that the hidden byte is kept when the accumulator narrows. Only the bench's scenarios can show the retention rules that run across several operations: the hidden byte showing again after widening, index bytes staying lost, and values surviving a round trip through emulation. The bench sweeps all four width combinations in native mode and emulation mode, loading every destination with edge-pattern values and copying between every register pair.

// File: rtl/mrf_pkg.sv
`timescale 1ns/1ps
// Shared types for the modal register file: operation codes, register
// selects, status bit positions and the N/Z flag helper.
package mrf_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = WORD_W / 2;
    localparam int IDX_N  = 2;

    localparam int C_POS = 0;
    localparam int Z_POS = 1;
    localparam int X_POS = 4;
    localparam int M_POS = 5;
    localparam int N_POS = 7;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_XFER = 3'd2,
        OP_SETP = 3'd3,
        OP_CLRP = 3'd4,
        OP_XCE  = 3'd5,
        OP_SWAP = 3'd6
    } mrf_op_e;

    typedef enum logic [2:0] {
        RS_ACC  = 3'd0,
        RS_IDX0 = 3'd1,
        RS_IDX1 = 3'd2,
        RS_STK  = 3'd3,
        RS_DPG  = 3'd4
    } mrf_reg_e;

    typedef struct packed {
        logic n;
        logic z;
    } mrf_nz_t;

    // Negative and zero flags of a value at the given width.
    function automatic mrf_nz_t nz_of(input logic [WORD_W-1:0] v, input logic wide);
        mrf_nz_t r;
        if (wide) begin
            r.n = v[WORD_W-1];
            r.z = (v == '0);
        end else begin
            r.n = v[BYTE_W-1];
            r.z = (v[BYTE_W-1:0] == '0);
        end
        return r;
    endfunction
endpackage

// File: rtl/mrf_mode_ctrl.sv
`timescale 1ns/1ps
// Status byte and hidden mode bit.
// Does: applies set/clear masks, the carry/mode exchange and N/Z updates,
// and forces both width flags while in emulation mode. It flags the cycle in
// which index upper bytes must be dropped (x narrowing or entering emulation).
// Assumes: at most one operation per cycle; N/Z updates come only from the
// register storage and never coincide with a status-mask operation.
module mrf_mode_ctrl
    import mrf_pkg::*;
#(
    parameter logic [7:0] RESET_P = 8'h34
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  mrf_op_e    op,
    input  logic [7:0] mask,
    input  logic       nz_we,
    input  mrf_nz_t    nz,
    output logic [7:0] p_q,
    output logic       e_q,
    output logic       m_w,
    output logic       x_w,
    output logic       narrow_idx,
    output logic       enter_emul
);
    logic [7:0] p_n;
    logic       e_n;
    logic       x_rise;

    // Next status and mode from the current operation.
    always_comb begin
        p_n        = p_q;
        e_n        = e_q;
        enter_emul = 1'b0;
        x_rise     = 1'b0;
        if (op_valid) begin
            case (op)
                OP_SETP: begin
                    p_n    = p_q | mask;
                    x_rise = mask[X_POS] & ~p_q[X_POS];
                end
                OP_CLRP: p_n = p_q & ~mask;
                OP_XCE: begin
                    e_n        = p_q[C_POS];
                    p_n[C_POS] = e_q;
                    enter_emul = p_q[C_POS] & ~e_q;
                end
                default: ;
            endcase
        end
        if (nz_we) begin
            p_n[N_POS] = nz.n;
            p_n[Z_POS] = nz.z;
        end
        if (e_n) begin
            p_n[M_POS] = 1'b1;
            p_n[X_POS] = 1'b1;
        end
    end

    assign narrow_idx = x_rise | enter_emul;

    // Status and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= RESET_P;
            e_q <= 1'b1;
        end else begin
            p_q <= p_n;
            e_q <= e_n;
        end
    end

    assign m_w = p_q[M_POS];
    assign x_w = p_q[X_POS];

    // R4
    emul_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_q |-> (m_w && x_w));

    // R2
    xce_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_XCE) |=>
            (e_q == $past(p_q[C_POS])) && (p_q[C_POS] == $past(e_q)));

    // R3
    set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SETP) |=> ((p_q & $past(mask)) == $past(mask)));
endmodule

// File: rtl/mrf_gpr.sv
`timescale 1ns/1ps
// Working register storage: accumulator, index registers, stack pointer,
// direct page.
// Does: performs loads and copies at the destination's width, the byte
// swap, index truncation and stack page forcing, and produces N/Z updates.
// Assumes: width flags and mode come from the status block's registered
// state; narrow_idx and enter_emul never coincide with a register write.
module mrf_gpr
    import mrf_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [WORD_W-1:0] RESET_S    = 16'h01FF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           op_valid,
    input  mrf_op_e                        op,
    input  logic [2:0]                     dst,
    input  logic [2:0]                     src,
    input  logic [WORD_W-1:0]              data,
    input  logic                           m_w,
    input  logic                           x_w,
    input  logic                           e_q,
    input  logic                           narrow_idx,
    input  logic                           enter_emul,
    output logic [WORD_W-1:0]              acc_o,
    output logic [IDX_N-1:0][WORD_W-1:0]   idx_o,
    output logic [WORD_W-1:0]              stk_o,
    output logic [WORD_W-1:0]              dpg_o,
    output logic                           nz_we,
    output mrf_nz_t                        nz
);
    logic [WORD_W-1:0] acc_q, stk_q, dpg_q;
    logic [WORD_W-1:0] idx_q [IDX_N];
    logic [WORD_W-1:0] src_v, wr_v;
    logic              is_wr, is_swap, full16, acc_wide;
    logic              dst_acc, dst_idx, dst_stk, dst_dpg;

    // Source selection for copies.
    always_comb begin
        case (src)
            RS_ACC:  src_v = acc_q;
            RS_IDX0: src_v = idx_q[0];
            RS_IDX1: src_v = idx_q[1];
            RS_STK:  src_v = stk_q;
            RS_DPG:  src_v = dpg_q;
            default: src_v = '0;
        endcase
    end

    // Write decode and width choice.
    always_comb begin
        is_wr    = op_valid && (op == OP_LOAD || op == OP_XFER);
        is_swap  = op_valid && (op == OP_SWAP);
        wr_v     = (op == OP_LOAD) ? data : src_v;
        dst_acc  = (dst == RS_ACC);
        dst_idx  = (dst == RS_IDX0) || (dst == RS_IDX1);
        dst_stk  = (dst == RS_STK);
        dst_dpg  = (dst == RS_DPG);
        full16   = (op == OP_XFER) &&
                   ((dst_acc && (src == RS_STK || src == RS_DPG)) ||
                    ((dst_stk || dst_dpg) && src == RS_ACC));
        acc_wide = !m_w || full16;
    end

    // Flag update: destination width for writes, low byte for the swap.
    always_comb begin
        nz_we = 1'b0;
        nz    = '0;
        if (is_swap) begin
            nz_we = 1'b1;
            nz    = nz_of({{BYTE_W{1'b0}}, acc_q[WORD_W-1:BYTE_W]}, 1'b0);
        end else if (is_wr) begin
            if (dst_acc) begin
                nz_we = 1'b1;
                nz    = nz_of(wr_v, acc_wide);
            end else if (dst_idx) begin
                nz_we = 1'b1;
                nz    = nz_of(wr_v, !x_w);
            end else if (dst_dpg) begin
                nz_we = 1'b1;
                nz    = nz_of(wr_v, 1'b1);
            end
        end
    end

    // Accumulator: narrow writes keep the hidden upper byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (is_swap) begin
            acc_q <= {acc_q[BYTE_W-1:0], acc_q[WORD_W-1:BYTE_W]};
        end else if (is_wr && dst_acc) begin
            acc_q <= acc_wide ? wr_v : {acc_q[WORD_W-1:BYTE_W], wr_v[BYTE_W-1:0]};
        end
    end

    // Index registers: one instance of the same write rule each.
    for (genvar g = 0; g < IDX_N; g++) begin : g_idx
        logic sel_me;
        assign sel_me = (dst == 3'(int'(RS_IDX0) + g));

        // Index register g: zero upper byte when narrow, truncate on event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[g] <= '0;
            end else if (is_wr && sel_me) begin
                idx_q[g] <= x_w ? {{BYTE_W{1'b0}}, wr_v[BYTE_W-1:0]} : wr_v;
            end else if (narrow_idx) begin
                idx_q[g] <= {{BYTE_W{1'b0}}, idx_q[g][BYTE_W-1:0]};
            end
        end

        assign idx_o[g] = idx_q[g];

        // R6
        idx_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            x_w |-> (idx_q[g][WORD_W-1:BYTE_W] == '0));
    end

    // Stack pointer: page fixed while in emulation mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= RESET_S;
        end else if (is_wr && dst_stk) begin
            stk_q <= e_q ? {STACK_PAGE, wr_v[BYTE_W-1:0]} : wr_v;
        end else if (enter_emul) begin
            stk_q <= {STACK_PAGE, stk_q[BYTE_W-1:0]};
        end
    end

    // Direct page: always a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpg_q <= '0;
        end else if (is_wr && dst_dpg) begin
            dpg_q <= wr_v;
        end
    end

    assign acc_o = acc_q;
    assign stk_o = stk_q;
    assign dpg_o = dpg_q;

    // R11
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_q |-> (stk_q[WORD_W-1:BYTE_W] == STACK_PAGE));

    // R8
    byte_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_swap |=> (acc_q == {$past(acc_q[BYTE_W-1:0]), $past(acc_q[WORD_W-1:BYTE_W])}));

    // R7
    hidden_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SETP) |=> $stable(acc_q));
endmodule

// File: rtl/mrf_read_port.sv
`timescale 1ns/1ps
// Combinational read port.
// Does: returns the selected register, zero-extended when the accumulator
// or the index registers are 8 bits wide; unused selects read zero.
// Assumes: width flags reflect the registered status byte.
module mrf_read_port
    import mrf_pkg::*;
(
    input  logic [2:0]                   sel,
    input  logic                         m_w,
    input  logic                         x_w,
    input  logic [WORD_W-1:0]            acc,
    input  logic [IDX_N-1:0][WORD_W-1:0] idx,
    input  logic [WORD_W-1:0]            stk,
    input  logic [WORD_W-1:0]            dpg,
    output logic [WORD_W-1:0]            rd
);
    localparam logic [BYTE_W-1:0] ZB = '0;

    // Register select with width-dependent masking.
    always_comb begin
        case (sel)
            RS_ACC:  rd = m_w ? {ZB, acc[BYTE_W-1:0]} : acc;
            RS_IDX0: rd = x_w ? {ZB, idx[0][BYTE_W-1:0]} : idx[0];
            RS_IDX1: rd = x_w ? {ZB, idx[1][BYTE_W-1:0]} : idx[1];
            RS_STK:  rd = stk;
            RS_DPG:  rd = dpg;
            default: rd = '0;
        endcase
    end
endmodule

// File: rtl/modal_regfile.sv
`timescale 1ns/1ps
// Dual-mode register file top.
// Does: joins status/mode control, register storage and the read port, and
// publishes the current operand widths and mode to the datapath.
// Assumes: one decoded operation per cycle, sampled on the rising edge.
module modal_regfile
    import mrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic [2:0]  op_dst,
    input  logic [2:0]  op_src,
    input  logic [15:0] op_data,
    input  logic [7:0]  op_mask,
    input  logic [2:0]  rd_sel,
    output logic [15:0] rd_data,
    output logic        m_eff,
    output logic        x_eff,
    output logic        e_flag,
    output logic [7:0]  status
);
    mrf_op_e                        op;
    logic [7:0]                     p_q;
    logic                           e_q, m_w, x_w, narrow_idx, enter_emul, nz_we;
    mrf_nz_t                        nz;
    logic [WORD_W-1:0]              acc, stk, dpg;
    logic [IDX_N-1:0][WORD_W-1:0]   idx;

    assign op = mrf_op_e'(op_code);

    mrf_mode_ctrl #(.RESET_P(8'h34)) mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op         (op),
        .mask       (op_mask),
        .nz_we      (nz_we),
        .nz         (nz),
        .p_q        (p_q),
        .e_q        (e_q),
        .m_w        (m_w),
        .x_w        (x_w),
        .narrow_idx (narrow_idx),
        .enter_emul (enter_emul)
    );

    mrf_gpr #(.STACK_PAGE(8'h01), .RESET_S(16'h01FF)) gpr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op         (op),
        .dst        (op_dst),
        .src        (op_src),
        .data       (op_data),
        .m_w        (m_w),
        .x_w        (x_w),
        .e_q        (e_q),
        .narrow_idx (narrow_idx),
        .enter_emul (enter_emul),
        .acc_o      (acc),
        .idx_o      (idx),
        .stk_o      (stk),
        .dpg_o      (dpg),
        .nz_we      (nz_we),
        .nz         (nz)
    );

    mrf_read_port rd_i (
        .sel (rd_sel),
        .m_w (m_w),
        .x_w (x_w),
        .acc (acc),
        .idx (idx),
        .stk (stk),
        .dpg (dpg),
        .rd  (rd_data)
    );

    assign m_eff  = m_w;
    assign x_eff  = x_w;
    assign e_flag = e_q;
    assign status = p_q;
endmodule

// File: tb/modal_regfile_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps widths, modes, destinations and copy pairs against an
// arithmetic expectation built from the requirements.
module modal_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0, op_dst = '0, op_src = '0, rd_sel = '0;
    logic [15:0] op_data = '0;
    logic [7:0]  op_mask = '0;
    logic [15:0] rd_data;
    logic        m_eff, x_eff, e_flag;
    logic [7:0]  status;

    int n_chk = 0;
    int n_err = 0;

    // expected state
    logic [15:0] eA, eX, eY, eS, eD;
    logic [7:0]  eP;
    logic        eE;

    logic [15:0] vals [7] = '{16'h0000, 16'h0080, 16'h8000, 16'h00FF,
                              16'hFF00, 16'h1234, 16'hFFFF};

    modal_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .op_src(op_src), .op_data(op_data), .op_mask(op_mask),
        .rd_sel(rd_sel), .rd_data(rd_data), .m_eff(m_eff), .x_eff(x_eff),
        .e_flag(e_flag), .status(status)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] raw(input logic [2:0] s);
        case (s)
            3'd0: return eA;
            3'd1: return eX;
            3'd2: return eY;
            3'd3: return eS;
            3'd4: return eD;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] s);
        case (s)
            3'd0: return eP[5] ? {8'h00, eA[7:0]} : eA;
            3'd1: return eP[4] ? {8'h00, eX[7:0]} : eX;
            3'd2: return eP[4] ? {8'h00, eY[7:0]} : eY;
            default: return raw(s);
        endcase
    endfunction

    task automatic set_nz(input logic [15:0] v, input logic wide);
        eP[7] = wide ? v[15] : v[7];
        eP[1] = wide ? (v == 16'h0) : (v[7:0] == 8'h0);
    endtask

    task automatic expect_op(input logic [2:0] op, input logic [2:0] dst,
                             input logic [2:0] src, input logic [15:0] d,
                             input logic [7:0] mk);
        logic [15:0] v;
        logic full, wide, oldE;
        case (op)
            3'd1, 3'd2: begin
                v = (op == 3'd1) ? d : raw(src);
                full = (op == 3'd2) && ((dst == 0 && (src == 3 || src == 4)) ||
                                        (src == 0 && (dst == 3 || dst == 4)));
                case (dst)
                    3'd0: begin wide = !eP[5] || full;
                        eA = wide ? v : {eA[15:8], v[7:0]}; set_nz(v, wide); end
                    3'd1: begin wide = !eP[4];
                        eX = wide ? v : {8'h00, v[7:0]}; set_nz(v, wide); end
                    3'd2: begin wide = !eP[4];
                        eY = wide ? v : {8'h00, v[7:0]}; set_nz(v, wide); end
                    3'd3: eS = eE ? {8'h01, v[7:0]} : v;
                    3'd4: begin eD = v; set_nz(v, 1'b1); end
                    default: ;
                endcase
            end
            3'd3: begin
                if (!eP[4] && mk[4]) begin eX[15:8] = 8'h0; eY[15:8] = 8'h0; end
                eP = eP | mk;
                if (eE) eP[5:4] = 2'b11;
            end
            3'd4: begin
                eP = eP & ~mk;
                if (eE) eP[5:4] = 2'b11;
            end
            3'd5: begin
                oldE = eE; eE = eP[0]; eP[0] = oldE;
                if (eE && !oldE) begin
                    eP[5:4] = 2'b11; eX[15:8] = 8'h0; eY[15:8] = 8'h0; eS[15:8] = 8'h01;
                end
            end
            3'd6: begin eA = {eA[7:0], eA[15:8]}; set_nz(eA, 1'b0); end
            default: ;
        endcase
    endtask

    // One operation: drive at a falling edge, return at the next falling edge.
    task automatic apply(input logic [2:0] op, input logic [2:0] dst,
                         input logic [2:0] src, input logic [15:0] d,
                         input logic [7:0] mk);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_dst = dst; op_src = src;
        op_data = d; op_mask = mk;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        expect_op(op, dst, src, d, mk);
    endtask

    task automatic check_all(input string req);
        chk({15'h0, e_flag}, {15'h0, eE}, req, "e_flag");
        chk({8'h0, status}, {8'h0, eP}, req, "status");
        chk({15'h0, m_eff}, {15'h0, eP[5]}, req, "m_eff");
        chk({15'h0, x_eff}, {15'h0, eP[4]}, req, "x_eff");
        for (int s = 0; s < 6; s++) begin
            rd_sel = 3'(s);
            #0.2;
            chk(rd_data, exp_rd(3'(s)), req, $sformatf("read sel %0d", s));
        end
    endtask

    // Width sweep: loads, copies and swaps for every value.
    task automatic sweep(input string req);
        for (int i = 0; i < 7; i++) begin
            for (int d = 0; d < 5; d++) begin
                apply(3'd1, 3'(d), 3'd0, vals[i] ^ 16'(d * 16'h0101), 8'h0);
                check_all({req, " R10 R12"});
            end
            apply(3'd6, 3'd0, 3'd0, 16'h0, 8'h0);
            check_all("R8");
        end
        for (int d = 0; d < 5; d++) begin
            for (int s = 0; s < 5; s++) begin
                apply(3'd2, 3'(d), 3'(s), 16'h0, 8'h0);
                check_all({req, " R9 R10"});
            end
        end
    endtask

    initial begin
        eA = 0; eX = 0; eY = 0; eS = 16'h01FF; eD = 0; eP = 8'h34; eE = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // emulation: clear mask cannot lower widths
        apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h30);
        check_all("R4");
        chk({14'h0, m_eff, x_eff}, 16'h3, "R4", "widths held");
        sweep("R11");

        // enter native with carry cleared; hidden byte retained
        apply(3'd1, 3'd0, 3'd0, 16'h00C3, 8'h0);
        apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h01);
        apply(3'd5, 3'd0, 3'd0, 16'h0, 8'h0);
        check_all("R2 R5");
        chk({15'h0, status[0]}, 16'h1, "R2", "carry holds old mode");

        for (int mx = 0; mx < 4; mx++) begin
            apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h30);
            apply(3'd3, 3'd0, 3'd0, 16'h0, 8'(mx << 4));
            check_all("R3");
            sweep("R3");
        end

        // R6: index narrowing loses upper byte
        apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h30);
        apply(3'd1, 3'd1, 3'd0, 16'hBEEF, 8'h0);
        apply(3'd3, 3'd0, 3'd0, 16'h0, 8'h10);
        apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h10);
        rd_sel = 3'd1; #0.2;
        chk(rd_data, 16'h00EF, "R6", "index after narrow/widen");
        check_all("R6");

        // R7: accumulator narrowing keeps hidden byte
        apply(3'd1, 3'd0, 3'd0, 16'hA55A, 8'h0);
        apply(3'd3, 3'd0, 3'd0, 16'h0, 8'h20);
        rd_sel = 3'd0; #0.2;
        chk(rd_data, 16'h005A, "R7", "narrow accumulator read");
        apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h20);
        rd_sel = 3'd0; #0.2;
        chk(rd_data, 16'hA55A, "R7", "hidden byte restored");
        check_all("R7");

        // R2: exchange with carry clear stays native
        apply(3'd4, 3'd0, 3'd0, 16'h0, 8'h01);
        apply(3'd5, 3'd0, 3'd0, 16'h0, 8'h0);
        chk({15'h0, e_flag}, 16'h0, "R2", "stays native");
        check_all("R2");

        // R11: entering emulation forces stack page and truncates index
        apply(3'd1, 3'd3, 3'd0, 16'h3456, 8'h0);
        apply(3'd1, 3'd2, 3'd0, 16'h1234, 8'h0);
        apply(3'd3, 3'd0, 3'd0, 16'h0, 8'h01);
        apply(3'd5, 3'd0, 3'd0, 16'h0, 8'h0);
        rd_sel = 3'd3; #0.2;
        chk(rd_data, 16'h0156, "R11", "stack page forced");
        rd_sel = 3'd2; #0.2;
        chk(rd_data, 16'h0034, "R11", "index truncated");
        check_all("R11");
        sweep("R11");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule